// File: doc/BRIEF.md
# Compare-Period Up Counter Timer

This block is a single periodic timer that counts upward against a programmable compare value. Software programs the period through a 16-bit compare register and starts or stops the timer through a 16-bit mode register. The mode register is reachable as two byte lanes or as one halfword. While the timer runs, each cycle with the tick input high advances the counter by one. When the counter would reach the captured period, the timer raises a one-clock interrupt pulse, returns to zero and carries on.

The period is latched only when count-enable is written. A later compare write therefore changes nothing until the timer is enabled again. Reading the counter gives the number of ticks since the last restart, or zero while the timer is stopped. Illegal writes are discarded whole and are flagged on an error pulse: a bad width, a bad address, a reserved bit set, or enable and load requested together.

Top module: `cmp_up_timer`

## Requirements
- R1: After reset the counter reads 0, the timer is stopped, and the interrupt and error outputs are low.
- R2: A legal write of the high mode byte with count-enable set (bit 7 of that byte, bit 15 of the halfword) and a nonzero compare value starts the timer. The counter reads 0 in the next cycle and then rises by one for each cycle with tick high.
- R3: With period P captured, the tick that would take the counter to P instead returns it to 0 and raises the interrupt for exactly one cycle. Counting then continues, so the counter never reads P or above.
- R4: While stopped the counter reads 0. A high-byte write with count-enable clear stops the timer at once, and the counter reads 0 from the next cycle.
- R5: The period is captured from the compare register only at the enabling write. Compare writes while running do not change the current period.
- R6: An enabling write while running restarts from 0 with the current compare value. The tick of that cycle is discarded and no interrupt is raised, even if that tick would have completed a period.
- R7: An enabling write while the compare register holds 0 leaves the timer stopped, with the counter at 0.
- R8: The legal accesses are: size 1 or 2 at 0x84, size 1 at 0x85, and size 2 at 0x86. Any other size or address pulses the error output one cycle later, and the write has no effect.
- R9: A write is rejected with the error pulse and no effect if it sets a reserved low-byte bit (mask 0x26) or a reserved high-byte bit (mask 0x07). It is also rejected if it sets both count-enable and load (bit 6 of the high byte). Other low-byte values are accepted silently.
- R10: A size-2 write at 0x84 carries the low mode byte in data bits 7:0 and the high mode byte in bits 15:8. A size-2 write at 0x86 loads the compare register from data bits 15:0. A period of 1 gives an interrupt on every tick.
- R11: Cycles with tick low leave the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count strobe; one count per cycle while high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Byte address of the write |
| wr_size_i | input | 3 | Access width in bytes |
| wr_data_i | input | 16 | Write data, right-aligned |
| count_o | output | 16 | Counter read value |
| irq_o | output | 1 | One-cycle period interrupt |
| wr_err_o | output | 1 | One-cycle pulse after a rejected write |

## Verification
Two pairs of events can fall in one cycle: a mode write and a period wrap, and a compare write and a period wrap. The bench provokes the first by watching the counter and issuing an enabling write in the cycle before the wrap would occur. It then checks that the interrupt stays low and the counter restarts at 0. For the second, it reprograms the compare value during running periods and confirms that wraps keep following the captured period. A behavioural model tracks every cycle and catches any slip in either case.

// File: rtl/cmp_up_timer_pkg.sv
package cmp_up_timer_pkg;

    localparam int unsigned BYTE_W      = 8;
    localparam logic [7:0]  LO_RSV_MASK = 8'h26;
    localparam logic [7:0]  HI_RSV_MASK = 8'h07;
    localparam int unsigned CE_BIT      = 7;
    localparam int unsigned LD_BIT      = 6;

    typedef struct packed {
        logic mode_wr;   // high mode byte accepted
        logic ce;        // count-enable value written
        logic cmp_wr;    // compare register accepted
        logic err;       // write rejected
    } wr_cmd_t;

endpackage

// File: rtl/cmp_up_timer_decode.sv
module cmp_up_timer_decode
    import cmp_up_timer_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 16,
    parameter logic [ADDR_W-1:0] MODE_LO_ADDR = 8'h84,
    parameter logic [ADDR_W-1:0] MODE_HI_ADDR = 8'h85,
    parameter logic [ADDR_W-1:0] CMP_ADDR     = 8'h86
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [2:0]        wr_size,
    input  logic [DATA_W-1:0] wr_data,
    output wr_cmd_t           cmd,
    output logic [DATA_W-1:0] cmp_val
);

    logic             has_lo;
    logic             has_hi;
    logic             bad_access;
    logic             rsv_hit;
    logic [BYTE_W-1:0] lo_byte;
    logic [BYTE_W-1:0] hi_byte;
    logic             cmp_hit;

    // Lane steering and width/address legality.
    always_comb begin
        has_lo     = 1'b0;
        has_hi     = 1'b0;
        cmp_hit    = 1'b0;
        bad_access = 1'b0;
        lo_byte    = wr_data[BYTE_W-1:0];
        hi_byte    = wr_data[BYTE_W-1:0];
        if (wr_addr == MODE_LO_ADDR) begin
            has_lo = 1'b1;
            if (wr_size == 3'd2) begin
                has_hi  = 1'b1;
                hi_byte = wr_data[2*BYTE_W-1:BYTE_W];
            end else if (wr_size != 3'd1) begin
                bad_access = 1'b1;
            end
        end else if (wr_addr == MODE_HI_ADDR) begin
            if (wr_size == 3'd1) begin
                has_hi = 1'b1;
            end else begin
                bad_access = 1'b1;
            end
        end else if (wr_addr == CMP_ADDR) begin
            if (wr_size == 3'd2) begin
                cmp_hit = 1'b1;
            end else begin
                bad_access = 1'b1;
            end
        end else begin
            bad_access = 1'b1;
        end
    end

    // Field-level legality.
    always_comb begin
        rsv_hit = 1'b0;
        if (has_lo && ((lo_byte & LO_RSV_MASK) != '0)) begin
            rsv_hit = 1'b1;
        end
        if (has_hi && ((hi_byte & HI_RSV_MASK) != '0)) begin
            rsv_hit = 1'b1;
        end
        if (has_hi && hi_byte[CE_BIT] && hi_byte[LD_BIT]) begin
            rsv_hit = 1'b1;
        end
    end

    always_comb begin
        cmd     = '0;
        cmp_val = wr_data;
        if (wr_en) begin
            cmd.err = bad_access | rsv_hit;
            if (!cmd.err) begin
                cmd.mode_wr = has_hi;
                cmd.ce      = has_hi & hi_byte[CE_BIT];
                cmd.cmp_wr  = cmp_hit;
            end
        end
    end

    always_comb begin
        if (cmd.err) begin
            assert_err_blocks_write_R8: assert (!cmd.mode_wr && !cmd.cmp_wr)
                else $error("rejected write still produced an update");
        end
    end

endmodule

// File: rtl/cmp_up_timer_core.sv
module cmp_up_timer_core
    import cmp_up_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  wr_cmd_t          cmd,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] count,
    output logic             irq,
    output logic             err
);

    localparam logic [CNT_W:0] ONE_X = {{CNT_W{1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] cmp;
        logic             run;
        logic             irq;
        logic             err;
    } state_t;

    state_t st_q;
    state_t st_d;
    logic [CNT_W:0] inc_x;
    logic           wrap;

    always_comb begin
        inc_x = {1'b0, st_q.count} + ONE_X;
        wrap  = (inc_x == {1'b0, st_q.period});
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        st_d.err = cmd.err;
        if (cmd.cmp_wr) begin
            st_d.cmp = cmp_val;
        end
        if (cmd.mode_wr) begin
            st_d.count = '0;
            if (cmd.ce && (st_q.cmp != '0)) begin
                st_d.run    = 1'b1;
                st_d.period = st_q.cmp;
            end else begin
                st_d.run = 1'b0;
            end
        end else if (st_q.run && tick) begin
            if (wrap) begin
                st_d.count = '0;
                st_d.irq   = 1'b1;
            end else begin
                st_d.count = inc_x[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.count;
    assign irq   = st_q.irq;
    assign err   = st_q.err;

    assert_cnt_below_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.count < st_q.period))
        else $error("counter reached its period");

    assert_irq_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> (st_q.count == '0 && st_q.run))
        else $error("interrupt without restart");

    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run |-> (st_q.count == '0))
        else $error("stopped counter not zero");

    assert_stop_now_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.mode_wr && !cmd.ce) |=> (!st_q.run && !st_q.irq))
        else $error("timer kept running after disable");

    assert_restart_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.mode_wr |=> (!st_q.irq && st_q.count == '0))
        else $error("mode write did not restart cleanly");

    assert_zero_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.mode_wr && st_q.cmp == '0) |=> !st_q.run)
        else $error("zero period started counting");

    assert_err_no_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.err |=> (st_q.err && $stable(st_q.run) && $stable(st_q.cmp) && $stable(st_q.period)))
        else $error("rejected write changed state");

    assert_hold_no_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cmd.mode_wr) |=> $stable(st_q.count))
        else $error("counter moved without tick");

endmodule

// File: rtl/cmp_up_timer.sv
module cmp_up_timer
    import cmp_up_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [2:0]        wr_size_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              irq_o,
    output logic              wr_err_o
);

    wr_cmd_t          cmd;
    logic [CNT_W-1:0] cmp_val;

    cmp_up_timer_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (CNT_W)
    ) decode_i (
        .wr_en   (wr_en_i),
        .wr_addr (wr_addr_i),
        .wr_size (wr_size_i),
        .wr_data (wr_data_i),
        .cmd     (cmd),
        .cmp_val (cmp_val)
    );

    cmp_up_timer_core #(
        .CNT_W (CNT_W)
    ) core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_i),
        .cmd     (cmd),
        .cmp_val (cmp_val),
        .count   (count_o),
        .irq     (irq_o),
        .err     (wr_err_o)
    );

endmodule

// File: tb/cmp_up_timer_tb_top.sv
module cmp_up_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [7:0]  wr_addr_i = '0;
    logic [2:0]  wr_size_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] count_o;
    logic        irq_o;
    logic        wr_err_o;

    int n_tests = 0;
    int n_fail  = 0;
    string cur_req = "R1";
    bit cmp_on = 1'b0;

    always #2 clk = ~clk;

    cmp_up_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_size_i(wr_size_i), .wr_data_i(wr_data_i),
        .count_o(count_o), .irq_o(irq_o), .wr_err_o(wr_err_o)
    );

    // Behavioural reference model.
    int m_cnt, m_per, m_cmp, m_lo, m_hi;
    bit m_run, m_irq, m_err, m_bad, m_hi_ok;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_per = 0; m_cmp = 0; m_run = 0; m_irq = 0; m_err = 0;
        end else begin
            m_irq = 0; m_bad = 0; m_hi_ok = 0; m_err = 0;
            m_lo = 0; m_hi = 0;
            if (wr_en_i) begin
                if (wr_addr_i == 8'h84) begin
                    m_lo = wr_data_i & 255;
                    if (wr_size_i == 2) begin m_hi_ok = 1; m_hi = wr_data_i >> 8; end
                    else if (wr_size_i != 1) m_bad = 1;
                    if ((m_lo & 'h26) != 0) m_bad = 1;
                end else if (wr_addr_i == 8'h85) begin
                    if (wr_size_i == 1) begin m_hi_ok = 1; m_hi = wr_data_i & 255; end
                    else m_bad = 1;
                end else if (wr_addr_i == 8'h86) begin
                    if (wr_size_i != 2) m_bad = 1;
                end else m_bad = 1;
                if (m_hi_ok && ((m_hi & 7) != 0)) m_bad = 1;
                if (m_hi_ok && ((m_hi & 'hC0) == 'hC0)) m_bad = 1;
                m_err = m_bad;
            end
            if (wr_en_i && !m_bad && m_hi_ok) begin
                m_cnt = 0;
                if ((m_hi & 'h80) != 0 && m_cmp != 0) begin m_run = 1; m_per = m_cmp; end
                else m_run = 0;
            end else if (m_run && tick_i) begin
                if (m_cnt + 1 == m_per) begin m_cnt = 0; m_irq = 1; end
                else m_cnt = m_cnt + 1;
            end
            if (wr_en_i && !m_bad && wr_addr_i == 8'h86) m_cmp = wr_data_i;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk(cur_req, "count_o", int'(count_o), m_cnt);
            chk(cur_req, "irq_o", int'(irq_o), int'(m_irq));
            chk(cur_req, "wr_err_o", int'(wr_err_o), int'(m_err));
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [2:0] s, logic [15:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_size_i = s; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic wait_count(int v, output bit seen);
        seen = 0;
        for (int i = 0; i < 40 && !seen; i++) begin
            if (int'(count_o) == v) seen = 1;
            else @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual expired expected done");
        summary();
        $finish;
    end

    initial begin
        int nirq;
        bit seen;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1", "count after reset", int'(count_o), 0);
        chk("R1", "irq after reset", int'(irq_o), 0);
        chk("R1", "err after reset", int'(wr_err_o), 0);
        cmp_on = 1'b1;

        cur_req = "R10";
        wr(8'h86, 2, 16'd5);
        cur_req = "R2";
        tick_i = 1'b1;
        wr(8'h85, 1, 16'h0080);
        chk("R2", "count at start", int'(count_o), 0);
        idle(3);
        chk("R2", "count after 3 ticks", int'(count_o), 3);

        cur_req = "R3";
        nirq = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (irq_o) nirq++; end
        chk("R3", "irq pulses in 20 ticks", nirq, 4);

        cur_req = "R11";
        for (int i = 0; i < 30; i++) begin tick_i = (i % 3 == 0); @(negedge clk); end
        tick_i = 1'b1;

        cur_req = "R5";
        wr(8'h86, 2, 16'd3);
        wait_count(4, seen);
        chk("R5", "old period still used", int'(seen), 1);

        cur_req = "R6";
        wait_count(1, seen);
        wr(8'h85, 1, 16'h0080);
        chk("R6", "restart count", int'(count_o), 0);
        wait_count(2, seen);
        wr(8'h85, 1, 16'h0080);
        chk("R6", "irq on collision", int'(irq_o), 0);
        chk("R6", "count on collision", int'(count_o), 0);
        idle(6);

        cur_req = "R4";
        wait_count(2, seen);
        wr(8'h85, 1, 16'h0000);
        chk("R4", "count after stop", int'(count_o), 0);
        idle(5);
        chk("R4", "count while stopped", int'(count_o), 0);

        cur_req = "R7";
        wr(8'h86, 2, 16'd0);
        wr(8'h85, 1, 16'h0080);
        nirq = 0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); if (irq_o || count_o != 0) nirq++; end
        chk("R7", "zero period activity", nirq, 0);

        cur_req = "R8";
        wr(8'h86, 2, 16'd4);
        wr(8'h85, 1, 16'h0080);
        idle(2);
        wr(8'h85, 2, 16'h0000);
        chk("R8", "err size2 at hi", int'(wr_err_o), 1);
        wr(8'h84, 4, 16'h0000);
        chk("R8", "err size4", int'(wr_err_o), 1);
        wr(8'h86, 1, 16'h0009);
        chk("R8", "err size1 at cmp", int'(wr_err_o), 1);
        wr(8'h90, 1, 16'h0000);
        chk("R8", "err bad address", int'(wr_err_o), 1);
        idle(6);

        cur_req = "R9";
        wr(8'h84, 1, 16'h0020);
        chk("R9", "err low reserved", int'(wr_err_o), 1);
        wr(8'h85, 1, 16'h0081);
        chk("R9", "err high reserved", int'(wr_err_o), 1);
        wr(8'h85, 1, 16'h00C0);
        chk("R9", "err enable+load", int'(wr_err_o), 1);
        wr(8'h84, 1, 16'h00D9);
        chk("R9", "legal low byte", int'(wr_err_o), 0);
        idle(6);

        cur_req = "R10";
        wr(8'h86, 2, 16'd2);
        wr(8'h84, 2, 16'h8000);
        idle(4);
        wr(8'h86, 2, 16'd1);
        wr(8'h84, 2, 16'h8000);
        @(negedge clk);
        chk("R10", "period 1 irq", int'(irq_o), 1);
        @(negedge clk);
        chk("R10", "period 1 irq again", int'(irq_o), 1);
        wr(8'h84, 2, 16'h4000);
        chk("R10", "load-only stops", int'(count_o), 0);
        idle(3);

        cmp_on = 1'b0;
        summary();
        $finish;
    end

endmodule